// File: doc/BRIEF.md
# PRBS Training Error Counter

This block checks write-training traffic on a group of data lanes. Each lane carries one received bit per beat. A local pseudo-random generator for each lane predicts what the transmitter sent, and every mismatch is counted. Because the generators stay in step with the transmitter, training can run for a long time without reloading a pattern. The host can leave out individual lanes through a lane mask. It can also leave out one or both eyes of the three-level signal through an eye mask. Errors are kept either as one count per lane or as separate counts for the lower and upper eye of each lane.

The host programs a base seed and issues a clear to start a run. It sends beats qualified by a valid strobe. While training runs or after it ends, the host reads any counter through a small registered read port. Each lane tags its beat with the eye the symbol crossed, so the block can filter and sort errors by eye.

Top module: `trn_err_mon`

## Requirements
- R1: After reset every counter reads zero and the read data output is zero.
- R2: Each lane's generator is a 15-bit shift register with polynomial x^15 + x^14 + 1. The expected bit is state bit 14. The next state is {state[13:0], state[14] ^ state[13]}. The generator advances only on cycles with valid high and clear low.
- R3: A clear loads lane L's generator with baseSeed XOR L. When that value is zero, the generator is loaded with 15'h7FFF instead.
- R4: On a valid beat where an unmasked lane's received bit differs from its expected bit, the selected counter of that lane increases by exactly one.
- R5: A lane whose laneMask bit is 1 adds no counts, but its generator still advances. Correct data sent after the lane is unmasked therefore counts no errors.
- R6: Each lane's rxEye bit selects the eye of its beat (0 lower, 1 upper). When eyeMask[rxEye] is 1, that beat adds no count.
- R7: Counter address is lane*2 + eye. With eyeMode 1, errors go to the counter at the beat's rxEye. With eyeMode 0, all errors of a lane go to address lane*2, and odd addresses do not change.
- R8: A counter holds at 16'hFFFF instead of wrapping.
- R9: A clear sets every counter to zero and reloads every generator in the same cycle. It takes priority over a valid beat in that cycle. The host issues a clear before each run.
- R10: rdData shows the counter at rdAddr as it stood before the clock edge that registers it, so it appears one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clrCmd | input | 1 | Synchronous clear of counters and reload of generators |
| rxValid | input | 1 | Beat qualifier |
| rxData | input | NUM_LANES | Received bit per lane |
| rxEye | input | NUM_LANES | Eye of each lane's beat (0 lower, 1 upper) |
| laneMask | input | NUM_LANES | 1 excludes the lane from counting |
| eyeMask | input | 2 | 1 excludes that eye from counting |
| eyeMode | input | 1 | 1 keeps counts per eye, 0 per lane |
| baseSeed | input | 15 | Base generator seed |
| rdAddr | input | ADDR_W | Counter address, lane*2 + eye |
| rdData | output | CNT_W | Registered counter value |

## Verification
A generator that slips by even one beat, or that was seeded wrongly, shows up as a flood of counts on clean traffic. That flood is visible on the next read of that lane. A counter that wraps, or that lands in the wrong eye slot, shows a wrong value on the first read of that address after the stimulus. Masked-lane misalignment appears only after unmasking, so clean beats are always sent after a masked stretch before reading.

// File: rtl/trn_pkg.sv
package trn_pkg;
  localparam int LFSR_W = 15;
  localparam int EYES   = 2;

  typedef struct packed {
    logic clearAll;
    logic step;
    logic perEye;
  } trnStrobe_t;
endpackage

// File: rtl/trn_lfsr.sv
module trn_lfsr
  import trn_pkg::*;
#(
  parameter int LANE_IDX = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LFSR_W-1:0] baseSeed,
  input  logic              load,
  input  logic              step,
  output logic              expBit
);
  logic [LFSR_W-1:0] state;
  logic [LFSR_W-1:0] seedRaw;
  logic [LFSR_W-1:0] seedVal;

  assign seedRaw = baseSeed ^ LFSR_W'(LANE_IDX);
  assign seedVal = (seedRaw == '0) ? '1 : seedRaw;
  assign expBit  = state[LFSR_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     state <= '1;
    else if (load) state <= seedVal;
    else if (step) state <= {state[LFSR_W-2:0], state[LFSR_W-1] ^ state[LFSR_W-2]};
  end

  // R2: shift register never locks up at zero
  a_r2_nonzero: assert property (@(posedge clk) disable iff (!rstN) state != '0);
  // R2: no advance without a qualified beat
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !step) |=> $stable(state));
endmodule

// File: rtl/trn_ctrl.sv
module trn_ctrl
  import trn_pkg::*;
(
  input  logic       clrCmd,
  input  logic       rxValid,
  input  logic       eyeMode,
  output trnStrobe_t strb
);
  always_comb begin
    strb.clearAll = clrCmd;
    strb.step     = rxValid & ~clrCmd;
    strb.perEye   = eyeMode;
  end
endmodule

// File: rtl/trn_datapath.sv
module trn_datapath
  import trn_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 16,
  localparam int NUM_CNT  = NUM_LANES * EYES,
  localparam int ADDR_W   = $clog2(NUM_CNT)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  trnStrobe_t           strb,
  input  logic [NUM_LANES-1:0] rxData,
  input  logic [NUM_LANES-1:0] rxEye,
  input  logic [NUM_LANES-1:0] laneMask,
  input  logic [EYES-1:0]      eyeMask,
  input  logic [LFSR_W-1:0]    baseSeed,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [CNT_W-1:0]     rdData
);
  logic [NUM_LANES-1:0] expBits;
  logic [NUM_LANES-1:0] laneMiss;
  logic [NUM_CNT-1:0]   hitVec;
  logic [CNT_W-1:0]     cnt [NUM_CNT];

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    trn_lfsr #(.LANE_IDX(l)) lfsr_i (
      .clk      (clk),
      .rstN     (rstN),
      .baseSeed (baseSeed),
      .load     (strb.clearAll),
      .step     (strb.step),
      .expBit   (expBits[l])
    );

    assign laneMiss[l] = strb.step & (rxData[l] ^ expBits[l])
                       & ~laneMask[l] & ~eyeMask[rxEye[l]];

    for (genvar e = 0; e < EYES; e++) begin : g_eye
      assign hitVec[l*EYES+e] = laneMiss[l] &
        (strb.perEye ? (rxEye[l] == 1'(e)) : (e == 0));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CNT; i++) cnt[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_CNT; i++) begin
        if (strb.clearAll)                 cnt[i] <= '0;
        else if (hitVec[i] && cnt[i] != '1) cnt[i] <= cnt[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if ({1'b0, rdAddr} < (ADDR_W+1)'(NUM_CNT)) rdData <= cnt[rdAddr];
    else rdData <= '0;
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rstN)
      (cnt[i] == '1 && !strb.clearAll) |=> cnt[i] == '1);
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rstN)
      !strb.clearAll |=> (cnt[i] == $past(cnt[i]) || cnt[i] == $past(cnt[i]) + 1'b1));
    a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
      strb.clearAll |=> cnt[i] == '0);
    a_r5_lane_mask: assert property (@(posedge clk) disable iff (!rstN)
      (laneMask[i/EYES] && !strb.clearAll) |=> $stable(cnt[i]));
    if (i % EYES != 0) begin : g_odd
      a_r7_eye_slot_idle: assert property (@(posedge clk) disable iff (!rstN)
        (!strb.perEye && !strb.clearAll) |=> $stable(cnt[i]));
    end
  end
endmodule

// File: rtl/trn_err_mon.sv
module trn_err_mon
  import trn_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 16,
  localparam int ADDR_W   = $clog2(NUM_LANES * EYES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clrCmd,
  input  logic                 rxValid,
  input  logic [NUM_LANES-1:0] rxData,
  input  logic [NUM_LANES-1:0] rxEye,
  input  logic [NUM_LANES-1:0] laneMask,
  input  logic [EYES-1:0]      eyeMask,
  input  logic                 eyeMode,
  input  logic [LFSR_W-1:0]    baseSeed,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [CNT_W-1:0]     rdData
);
  trnStrobe_t strb;

  trn_ctrl ctrl_i (
    .clrCmd  (clrCmd),
    .rxValid (rxValid),
    .eyeMode (eyeMode),
    .strb    (strb)
  );

  trn_datapath #(.NUM_LANES(NUM_LANES), .CNT_W(CNT_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rxData   (rxData),
    .rxEye    (rxEye),
    .laneMask (laneMask),
    .eyeMask  (eyeMask),
    .baseSeed (baseSeed),
    .rdAddr   (rdAddr),
    .rdData   (rdData)
  );
endmodule

// File: tb/trn_err_mon_tb_top.sv
`timescale 1ns/1ps
module trn_err_mon_tb_top;
  localparam int LANES = 4;
  localparam int CW    = 16;
  localparam int NC    = LANES * 2;
  localparam int AW    = $clog2(NC);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rstN, clrCmd, rxValid, eyeMode;
  logic [LANES-1:0] rxData, rxEye, laneMask;
  logic [1:0]       eyeMask;
  logic [14:0]      baseSeed;
  logic [AW-1:0]    rdAddr;
  logic [CW-1:0]    rdData;

  trn_err_mon #(.NUM_LANES(LANES), .CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .clrCmd(clrCmd), .rxValid(rxValid),
    .rxData(rxData), .rxEye(rxEye), .laneMask(laneMask), .eyeMask(eyeMask),
    .eyeMode(eyeMode), .baseSeed(baseSeed), .rdAddr(rdAddr), .rdData(rdData)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;
  always @(posedge clk) cyc++;

  typedef struct {
    int          addr;
    logic [15:0] exp;
    string       tag;
    int          due;
  } rdItem_t;
  rdItem_t rdQ[$];

  logic [14:0] mLfsr [LANES];
  logic [15:0] mCnt  [NC];

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops read expectations when their data is due
  always @(negedge clk) begin
    while (rdQ.size() > 0 && rdQ[0].due <= cyc) begin
      rdItem_t it;
      it = rdQ.pop_front();
      check(rdData === it.exp, $sformatf("%s addr=%0d", it.tag, it.addr), rdData, it.exp);
    end
  end

  function automatic logic [14:0] seedOf(input int lane);
    logic [14:0] s;
    s = baseSeed ^ 15'(lane);
    return (s == '0) ? 15'h7FFF : s;
  endfunction

  task automatic doClear();
    clrCmd  = 1'b1;
    rxValid = 1'b1;            // R9: valid in the clear cycle must be ignored
    rxData  = LANES'($urandom);
    @(negedge clk);
    clrCmd  = 1'b0;
    rxValid = 1'b0;
    for (int l = 0; l < LANES; l++) mLfsr[l] = seedOf(l);
    for (int i = 0; i < NC; i++) mCnt[i] = '0;
  endtask

  task automatic beat(input logic [LANES-1:0] errInj, input logic [LANES-1:0] eyeV);
    for (int l = 0; l < LANES; l++) rxData[l] = mLfsr[l][14] ^ errInj[l];
    rxEye   = eyeV;
    rxValid = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      int idx;
      idx = eyeMode ? l*2 + int'(eyeV[l]) : l*2;
      if (errInj[l] && !laneMask[l] && !eyeMask[eyeV[l]] && mCnt[idx] != 16'hFFFF)
        mCnt[idx] = mCnt[idx] + 1'b1;
      mLfsr[l] = {mLfsr[l][13:0], mLfsr[l][14] ^ mLfsr[l][13]};
    end
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      rxValid = 1'b0;
      rxData  = LANES'($urandom);   // R2: junk with valid low
      @(negedge clk);
    end
  endtask

  task automatic readChk(input int addr, input string tag);
    rdAddr = AW'(addr);
    rdQ.push_back('{addr, mCnt[addr], tag, cyc + 1});
    @(negedge clk);
  endtask

  task automatic readAll(input string tag);
    for (int a = 0; a < NC; a++) readChk(a, tag);
  endtask

  task automatic randBeats(input int n);
    for (int k = 0; k < n; k++) beat(LANES'($urandom), LANES'($urandom));
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; clrCmd = 0; rxValid = 0; rxData = '0; rxEye = '0;
    laneMask = '0; eyeMask = '0; eyeMode = 0; baseSeed = 15'h0001; rdAddr = '0;
    for (int i = 0; i < NC; i++) mCnt[i] = '0;
    repeat (3) @(negedge clk);
    check(rdData === '0, "R1 rdData after reset", rdData, '0);
    rstN = 1'b1;
    @(negedge clk);
    readAll("R1 counter after reset");

    // R3: base seed 1 makes lane 1 seed zero -> substitute; R9 clear with valid
    doClear();
    for (int k = 0; k < 40; k++) beat('0, LANES'($urandom));
    readAll("R3 clean beats after seeding");

    // R2: idle cycles must not advance generators
    idle(7);
    for (int k = 0; k < 30; k++) beat('0, LANES'($urandom));
    readAll("R2 alignment after idle");

    // R4 and R7: per-lane mode with random errors
    baseSeed = 15'h2A5C;
    doClear();
    randBeats(200);
    readAll("R4 R7 per-lane counts");

    // R7: per-eye mode
    eyeMode = 1'b1;
    doClear();
    randBeats(200);
    readAll("R7 per-eye counts");

    // R5: masked lane keeps generator running
    laneMask = 4'b0010;
    randBeats(100);
    laneMask = '0;
    for (int k = 0; k < 30; k++) beat('0, LANES'($urandom));
    readAll("R5 lane mask");

    // R6: eye mask
    eyeMask = 2'b01;
    randBeats(150);
    readAll("R6 lower eye masked");
    eyeMask = 2'b10;
    randBeats(150);
    readAll("R6 upper eye masked");
    eyeMask = '0;

    // R9: clear mid-run
    doClear();
    readAll("R9 clear");

    // R8: saturation on lane 0 only
    eyeMode  = 1'b0;
    laneMask = 4'b1110;
    doClear();
    for (int k = 0; k < 65540; k++) beat('1, '0);
    readChk(0, "R8 saturated counter");
    readChk(1, "R7 odd slot untouched");
    readChk(2, "R5 masked lane zero");
    laneMask = '0;

    doClear();
    readChk(0, "R9 clear after saturation");
    repeat (3) @(negedge clk);
    check(rdQ.size() == 0, "R10 read queue drained", 16'(rdQ.size()), '0);

    done = 1;
    summary();
    $finish;
  end
endmodule